// File: doc/BRIEF.md
# Hash Register Front-End

This block is the register interface that a 32-bit processor uses to drive a streaming SHA-384/SHA-512 engine. Software first takes ownership by reading a semaphore. It then picks the algorithm, zeroizes the engine and writes a running byte count. Message words go to the engine through a single data port, one bus write per word. A write to the execute register starts the final digest. When the engine finishes, the digest is held in a bank of readable words and a status flag reports it as valid.

The front-end takes care of the stream-side details that software should not handle. It counts the words that have been accepted and compares that count with the byte length to mark the final word. It derives a byte-enable for a partial final word and can optionally swap byte order. While the engine is not ready, it stalls the bus with a wait signal. Writes that would disturb the engine are ignored until the lock is held. The compression function is outside this block: it sits behind the word-stream and digest-capture ports.

Top module: `hash_reg_front`

## Requirements
- R1: After reset, the lock, mode, length, status and all digest words read as 0. No stream word, start or zeroize pulse is presented.
- R2: When the lock is free, a read of offset 0x00 returns 0 and takes the lock. Reads made while the lock is held return 1. Status bit 1 mirrors the lock.
- R3: Writing a word with bit 0 set to offset 0x00 frees the lock. It also clears the digest-valid flag (status bit 0) and the word count.
- R4: While the lock is free, writes to data-in (0x14), execute (0x18) and mode (0x08) have no effect. No word is offered, no start pulse is raised and the mode reads back unchanged.
- R5: The length register at 0x10 holds the byte count as written and reads back the same value.
- R6: A data-in write made while the lock is held offers the word to the engine. `bus_wait` is high in every cycle in which the engine is not ready, and the word count advances only on an accepted word.
- R7: A word is last when (words already accepted + 1)·4 ≥ length. For a last word the byte-enable is taken from length mod 4: 0→1111, 1→1000, 2→1100, 3→1110, where bit 3 is byte [31:24]. A word that is not last has a byte-enable of 1111.
- R8: The earliest byte is in bits [31:24]. When mode bit 2 is 1, each forwarded word has its four bytes reversed; otherwise the word is forwarded unchanged.
- R9: Writing bit 0 to execute while the lock is held raises `eng_start` in the same cycle. It also clears the word count and the valid flag.
- R10: When `eng_done` is high, digest word n (read at 0x20+4n) takes bits [32·(15−n)+31 : 32·(15−n)] of `eng_digest` at that edge. Status bit 0 rises one cycle later.
- R11: When mode bits [1:0] are 0 (SHA-384), digest words 12 to 15 are captured as 0. A mode value of 1 selects SHA-512, and all 16 words are captured.
- R12: Writing bit 0 to control (0x60) pulses `eng_zeroize`, whether or not the lock is held. It clears every digest word, the valid flag and the word count.
- R13: `eng_mode` always equals mode bits [1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as `bus_rd` |
| bus_wait | output | 1 | Holds the current data-in write |
| eng_valid | output | 1 | Stream word offered |
| eng_ready | input | 1 | Engine accepts the offered word |
| eng_data | output | 32 | Stream word |
| eng_last | output | 1 | Offered word is the final one |
| eng_byte_en | output | 4 | Valid bytes of the offered word |
| eng_mode | output | 2 | Algorithm select |
| eng_start | output | 1 | Final-digest start pulse |
| eng_zeroize | output | 1 | Engine state wipe pulse |
| eng_done | input | 1 | Digest ready, one cycle |
| eng_digest | input | 512 | Digest, word 0 most significant |

## Verification
A wrong word count shows up at once as an error in `eng_last` or `eng_byte_en` on the next data word. A lock that is held when it should be free shows up as words, start pulses or mode writes that leak through, visible in the same cycle. The bench checks every stream output and every read value against a behavioural model in every cycle. A bad capture or a late valid flag therefore appears at the first status poll or digest read after `eng_done`, within a few cycles.

// File: rtl/hrf_pkg.sv
// Package: register offsets, mode layout and the byte-enable helper shared
// by the front-end modules. Assumes a byte-addressed bus with aligned words.
package hrf_pkg;
    localparam int WORD_W  = 32;
    localparam int BYTES   = WORD_W / 8;
    localparam int ADDR_W  = 8;

    localparam logic [ADDR_W-1:0] OFF_LOCK = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_MODE = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_LEN  = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_DIN  = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_EXEC = 8'h18;
    localparam logic [ADDR_W-1:0] OFF_STAT = 8'h1C;
    localparam logic [ADDR_W-1:0] OFF_DIG  = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_CTRL = 8'h60;

    localparam logic [1:0] ALGO_384 = 2'd0;
    localparam logic [1:0] ALGO_512 = 2'd1;

    typedef struct packed {
        logic       swap;
        logic [1:0] algo;
    } mode_t;

    // Byte-enable of a final word from the two low length bits.
    function automatic logic [BYTES-1:0] tail_mask(input logic [1:0] rem);
        case (rem)
            2'd1:    tail_mask = 4'b1000;
            2'd2:    tail_mask = 4'b1100;
            2'd3:    tail_mask = 4'b1110;
            default: tail_mask = 4'b1111;
        endcase
    endfunction
endpackage

// File: rtl/hrf_lock.sv
// Ownership semaphore. A read of a free lock takes it; a release request
// frees it. Assumes one requester at a time; release wins over acquire.
module hrf_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic acq_req,
    input  logic rel_req,
    output logic held
);
    // Semaphore state update.
    always_ff @(posedge clk) begin
        if (!rst_n)       held <= 1'b0;
        else if (rel_req) held <= 1'b0;
        else if (acq_req) held <= 1'b1;
    end

    assert_acquire_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acq_req && !held && !rel_req) |=> held);
    assert_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rel_req |=> !held);
endmodule

// File: rtl/hrf_stream.sv
// Data-in path: offers bus words to the engine, stalls the bus while the
// engine is not ready, counts accepted words and qualifies the final word
// from the byte length. Assumes the length is written before its words.
module hrf_stream
    import hrf_pkg::*;
#(
    parameter int LEN_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              din_wr,
    input  logic              held,
    input  logic              swap,
    input  logic [WORD_W-1:0] wdata,
    input  logic [LEN_W-1:0]  len,
    input  logic              cnt_clr,
    input  logic              eng_ready,
    output logic              eng_valid,
    output logic [WORD_W-1:0] eng_data,
    output logic              eng_last,
    output logic [BYTES-1:0]  eng_byte_en,
    output logic              stall
);
    localparam int CNT_W = LEN_W - 2;
    localparam int EXT_W = LEN_W + 1;

    logic [CNT_W-1:0]  cnt;
    logic [EXT_W-1:0]  end_byte;
    logic [WORD_W-1:0] swapped;

    // Byte reversal of the incoming word, one lane per byte.
    for (genvar g = 0; g < BYTES; g++) begin : g_swap
        assign swapped[8*g +: 8] = wdata[8*(BYTES-1-g) +: 8];
    end

    // Offer, stall and final-word qualification.
    always_comb begin
        eng_valid   = din_wr && held;
        stall       = eng_valid && !eng_ready;
        eng_data    = swap ? swapped : wdata;
        end_byte    = EXT_W'({cnt, 2'b00}) + EXT_W'(BYTES);
        eng_last    = end_byte >= EXT_W'(len);
        eng_byte_en = eng_last ? tail_mask(len[1:0]) : '1;
    end

    // Accepted-word counter.
    always_ff @(posedge clk) begin
        if (!rst_n)                      cnt <= '0;
        else if (cnt_clr)                cnt <= '0;
        else if (eng_valid && eng_ready) cnt <= cnt + 1'b1;
    end

    assert_count_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (cnt == '0));
    assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_clr && !(eng_valid && eng_ready)) |=> $stable(cnt));
endmodule

// File: rtl/hrf_digest.sv
// Digest bank: captures the engine result in one cycle on done, zeroes the
// unused words in the short mode, raises valid one cycle after capture.
// Assumes done is a single-cycle pulse; wipe beats capture.
module hrf_digest
    import hrf_pkg::*;
#(
    parameter int DIG_WORDS   = 16,
    parameter int SHORT_WORDS = 12,
    localparam int IDX_W      = $clog2(DIG_WORDS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        eng_done,
    input  logic [DIG_WORDS*WORD_W-1:0] eng_digest,
    input  logic                        short_mode,
    input  logic                        wipe,
    input  logic                        inval,
    input  logic [IDX_W-1:0]            rd_idx,
    output logic [WORD_W-1:0]           rd_word,
    output logic                        valid
);
    logic [WORD_W-1:0] bank [DIG_WORDS];
    logic              pend;

    // One capture register per digest word.
    for (genvar g = 0; g < DIG_WORDS; g++) begin : g_word
        localparam bit UPPER = (g >= SHORT_WORDS);
        always_ff @(posedge clk) begin
            if (!rst_n || wipe)
                bank[g] <= '0;
            else if (eng_done)
                bank[g] <= (UPPER && short_mode) ? '0
                         : eng_digest[(DIG_WORDS-1-g)*WORD_W +: WORD_W];
        end
    end

    // Valid follows capture by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || wipe || inval) begin
            pend  <= 1'b0;
            valid <= 1'b0;
        end else begin
            pend  <= eng_done;
            if (pend) valid <= 1'b1;
        end
    end

    // Read port.
    assign rd_word = bank[rd_idx];

    assert_valid_late_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid) |-> $past(eng_done, 2));
    assert_wipe_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wipe) |-> (!valid && rd_word == '0));
endmodule

// File: rtl/hash_reg_front.sv
// Register front-end between a 32-bit bus and a streaming hash engine.
// Decodes offsets, gates engine-side writes by ownership and muxes reads.
// Assumes reads and writes are never strobed in the same cycle.
module hash_reg_front
    import hrf_pkg::*;
#(
    parameter int DIG_WORDS   = 16,
    parameter int SHORT_WORDS = 12,
    parameter int LEN_W       = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_wr,
    input  logic                        bus_rd,
    input  logic [7:0]                  bus_addr,
    input  logic [31:0]                 bus_wdata,
    output logic [31:0]                 bus_rdata,
    output logic                        bus_wait,
    output logic                        eng_valid,
    input  logic                        eng_ready,
    output logic [31:0]                 eng_data,
    output logic                        eng_last,
    output logic [3:0]                  eng_byte_en,
    output logic [1:0]                  eng_mode,
    output logic                        eng_start,
    output logic                        eng_zeroize,
    input  logic                        eng_done,
    input  logic [DIG_WORDS*32-1:0]     eng_digest
);
    localparam int IDX_W = $clog2(DIG_WORDS);
    localparam logic [ADDR_W-1:0] DIG_SPAN = ADDR_W'(DIG_WORDS * BYTES);

    logic              held;
    logic              acq, rel, mode_wr, len_wr, din_wr;
    mode_t             mode_q;
    logic [LEN_W-1:0]  len_q;
    logic [ADDR_W-1:0] dig_off;
    logic              dig_hit;
    logic [WORD_W-1:0] dig_word;
    logic              dig_valid;

    // Write and read strobe decode.
    always_comb begin
        acq         = bus_rd && bus_addr == OFF_LOCK;
        rel         = bus_wr && bus_addr == OFF_LOCK && bus_wdata[0];
        mode_wr     = bus_wr && bus_addr == OFF_MODE && held;
        len_wr      = bus_wr && bus_addr == OFF_LEN;
        din_wr      = bus_wr && bus_addr == OFF_DIN;
        eng_start   = bus_wr && bus_addr == OFF_EXEC && bus_wdata[0] && held;
        eng_zeroize = bus_wr && bus_addr == OFF_CTRL && bus_wdata[0];
        dig_off     = bus_addr - OFF_DIG;
        dig_hit     = bus_addr >= OFF_DIG && dig_off < DIG_SPAN
                   && dig_off[1:0] == 2'b00;
    end

    // Mode and length registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            len_q  <= '0;
        end else begin
            if (mode_wr) mode_q <= mode_t'(bus_wdata[2:0]);
            if (len_wr)  len_q  <= bus_wdata[LEN_W-1:0];
        end
    end

    assign eng_mode = mode_q.algo;

    hrf_lock u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .acq_req (acq),
        .rel_req (rel),
        .held    (held)
    );

    hrf_stream #(.LEN_W(LEN_W)) u_stream (
        .clk         (clk),
        .rst_n       (rst_n),
        .din_wr      (din_wr),
        .held        (held),
        .swap        (mode_q.swap),
        .wdata       (bus_wdata),
        .len         (len_q),
        .cnt_clr     (eng_start || eng_zeroize || rel),
        .eng_ready   (eng_ready),
        .eng_valid   (eng_valid),
        .eng_data    (eng_data),
        .eng_last    (eng_last),
        .eng_byte_en (eng_byte_en),
        .stall       (bus_wait)
    );

    hrf_digest #(.DIG_WORDS(DIG_WORDS), .SHORT_WORDS(SHORT_WORDS)) u_digest (
        .clk        (clk),
        .rst_n      (rst_n),
        .eng_done   (eng_done),
        .eng_digest (eng_digest),
        .short_mode (mode_q.algo == ALGO_384),
        .wipe       (eng_zeroize),
        .inval      (rel || eng_start),
        .rd_idx     (dig_off[IDX_W+1:2]),
        .rd_word    (dig_word),
        .valid      (dig_valid)
    );

    // Read data mux.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                OFF_LOCK: bus_rdata = {31'b0, held};
                OFF_MODE: bus_rdata = {29'b0, mode_q};
                OFF_LEN:  bus_rdata = 32'(len_q);
                OFF_STAT: bus_rdata = {30'b0, held, dig_valid};
                default:  bus_rdata = dig_hit ? dig_word : '0;
            endcase
        end
    end

    assert_unlocked_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !held |-> (!eng_valid && !eng_start));
    assert_mode_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(held) |-> $stable(mode_q));
    assert_wait_offer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wait |-> (din_wr && held));
endmodule

// File: tb/sim_hash_reg_front.sv
module sim_hash_reg_front;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         bus_wait, eng_valid, eng_last, eng_start, eng_zeroize;
    logic         eng_ready = 1'b1, eng_done = 1'b0;
    logic [31:0]  eng_data;
    logic [3:0]   eng_byte_en;
    logic [1:0]   eng_mode;
    logic [511:0] eng_digest = '0;

    int checks = 0, fails = 0;
    bit finished = 0;
    bit stall_en = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    hash_reg_front u0 (.*);

    task automatic chk(input string tag, input bit ok,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit          m_lock, m_valid, m_pend;
    logic [2:0]  m_mode;
    logic [31:0] m_len;
    longint      m_cnt;
    logic [31:0] m_dig [16];

    function automatic logic [31:0] exp_rdata(input logic [7:0] a);
        if (a == 8'h00) return {31'b0, m_lock};
        if (a == 8'h08) return {29'b0, m_mode};
        if (a == 8'h10) return m_len;
        if (a == 8'h1C) return {30'b0, m_lock, m_valid};
        if (a >= 8'h20 && a < 8'h60 && a[1:0] == 2'b00) return m_dig[(a - 8'h20) >> 2];
        return 32'h0;
    endfunction

    function automatic string rd_tag(input logic [7:0] a);
        if (a == 8'h00) return "R2";
        if (a == 8'h08) return "R13";
        if (a == 8'h10) return "R5";
        return "R10";
    endfunction

    // Model expectations compared away from the clock edge, every cycle.
    always @(negedge clk) if (rst_n) begin
        bit e_valid, e_start, e_zero, e_last;
        logic [31:0] e_data;
        logic [3:0] e_be;
        e_valid = bus_wr && bus_addr == 8'h14 && m_lock;
        e_start = bus_wr && bus_addr == 8'h18 && bus_wdata[0] && m_lock;
        e_zero  = bus_wr && bus_addr == 8'h60 && bus_wdata[0];
        e_data  = m_mode[2] ? {bus_wdata[7:0], bus_wdata[15:8], bus_wdata[23:16], bus_wdata[31:24]}
                            : bus_wdata;
        e_last  = (m_cnt + 1) * 4 >= longint'(m_len);
        case (m_len[1:0])
            2'd1: e_be = 4'b1000;
            2'd2: e_be = 4'b1100;
            2'd3: e_be = 4'b1110;
            default: e_be = 4'b1111;
        endcase
        if (!e_last) e_be = 4'b1111;
        chk("R6 valid", eng_valid == e_valid, 32'(eng_valid), 32'(e_valid));
        chk("R6 wait", bus_wait == (e_valid && !eng_ready), 32'(bus_wait), 32'(e_valid && !eng_ready));
        chk("R9 start", eng_start == e_start, 32'(eng_start), 32'(e_start));
        chk("R12 zeroize", eng_zeroize == e_zero, 32'(eng_zeroize), 32'(e_zero));
        chk("R13 mode", eng_mode == m_mode[1:0], 32'(eng_mode), 32'(m_mode[1:0]));
        if (e_valid) begin
            chk("R8 data", eng_data == e_data, eng_data, e_data);
            chk("R7 last", eng_last == e_last, 32'(eng_last), 32'(e_last));
            chk("R7 byte_en", eng_byte_en == e_be, 32'(eng_byte_en), 32'(e_be));
        end
        if (bus_rd)
            chk(rd_tag(bus_addr), bus_rdata == exp_rdata(bus_addr), bus_rdata, exp_rdata(bus_addr));
    end

    // Model state update at the clock edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_lock = 0; m_valid = 0; m_pend = 0; m_mode = '0; m_len = '0; m_cnt = 0;
            foreach (m_dig[i]) m_dig[i] = '0;
        end else begin
            bit acq, rel, st, zr, hs, clr;
            acq = bus_rd && bus_addr == 8'h00 && !m_lock;
            rel = bus_wr && bus_addr == 8'h00 && bus_wdata[0];
            st  = bus_wr && bus_addr == 8'h18 && bus_wdata[0] && m_lock;
            zr  = bus_wr && bus_addr == 8'h60 && bus_wdata[0];
            hs  = bus_wr && bus_addr == 8'h14 && m_lock && eng_ready;
            clr = st || zr || rel;
            if (clr) m_cnt = 0; else if (hs) m_cnt++;
            if (zr) foreach (m_dig[i]) m_dig[i] = '0;
            else if (eng_done)
                for (int n = 0; n < 16; n++)
                    m_dig[n] = (m_mode[1:0] == 2'd0 && n >= 12) ? 32'h0 : eng_digest[(15-n)*32 +: 32];
            if (clr) begin m_valid = 0; m_pend = 0; end
            else begin if (m_pend) m_valid = 1; m_pend = eng_done; end
            if (bus_wr && bus_addr == 8'h08 && m_lock) m_mode = bus_wdata[2:0];
            if (bus_wr && bus_addr == 8'h10) m_len = bus_wdata;
            if (rel) m_lock = 0; else if (acq) m_lock = 1;
        end
    end

    // ---------------- engine stand-in ----------------
    int go_cnt = 0;
    int seed = 1;
    always @(posedge clk) begin
        bit s;
        s = eng_start;
        cyc++;
        #2;
        eng_ready = stall_en ? (cyc % 3 == 0) : 1'b1;
        eng_done = 1'b0;
        if (go_cnt > 0) begin
            go_cnt--;
            if (go_cnt == 0) begin
                for (int n = 0; n < 16; n++)
                    eng_digest[(15-n)*32 +: 32] = {seed[15:0], 16'(n * 16'h1111 + 1)};
                eng_done = 1'b1;
                seed++;
            end
        end
        if (s) go_cnt = 3;
    end

    // ---------------- bus tasks ----------------
    task automatic bwrite(input logic [7:0] a, input logic [31:0] d);
        bit w;
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        forever begin
            @(negedge clk); w = bus_wait;
            @(posedge clk);
            if (!w) break;
        end
        #2 bus_wr = 0;
    endtask

    task automatic bread(input logic [7:0] a, output logic [31:0] d);
        bus_rd = 1; bus_addr = a;
        @(negedge clk); d = bus_rdata;
        @(posedge clk); #2 bus_rd = 0;
    endtask

    task automatic poll_valid();
        logic [31:0] s;
        for (int k = 0; k < 30; k++) begin
            bread(8'h1C, s);
            if (s[0]) break;
        end
        chk("R10 status", s == 32'h3, s, 32'h3);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        logic [31:0] r;
        repeat (4) @(posedge clk);
        #2 rst_n = 1;
        @(posedge clk); #2;

        // R1: reset values
        bread(8'h1C, r); chk("R1 status", r == 0, r, 0);
        bread(8'h10, r); chk("R1 length", r == 0, r, 0);
        bread(8'h08, r); chk("R1 mode", r == 0, r, 0);
        bread(8'h3C, r); chk("R1 digest", r == 0, r, 0);

        // R4: unlocked writes ignored
        bwrite(8'h08, 32'h5);
        bwrite(8'h14, 32'hDEADBEEF);
        bwrite(8'h18, 32'h1);
        bread(8'h08, r); chk("R4 mode", r == 0, r, 0);
        bread(8'h1C, r); chk("R4 status", r == 0, r, 0);

        // R2: acquire
        bread(8'h00, r); chk("R2 first", r == 0, r, 0);
        bread(8'h00, r); chk("R2 held", r == 1, r, 1);
        bread(8'h1C, r); chk("R2 status", r == 32'h2, r, 32'h2);

        // SHA-512 with swap, 7 bytes, stalled engine
        bwrite(8'h60, 32'h1);
        bwrite(8'h10, 32'h0);
        bwrite(8'h08, 32'h5);
        bread(8'h08, r); chk("R13 mode", r == 5, r, 5);
        bwrite(8'h10, 32'd7);
        bread(8'h10, r); chk("R5 length", r == 7, r, 7);
        stall_en = 1;
        bwrite(8'h14, 32'h61626364);
        bwrite(8'h14, 32'h65666700);
        stall_en = 0;
        bwrite(8'h18, 32'h1);
        poll_valid();
        for (int n = 0; n < 16; n++) bread(8'(8'h20 + 4 * n), r);
        bread(8'h20, r); chk("R10 word0", r == 32'h00010001, r, 32'h00010001);

        // R3: release clears valid
        bwrite(8'h00, 32'h1);
        bread(8'h1C, r); chk("R3 status", r == 0, r, 0);
        bread(8'h00, r); chk("R3 free", r == 0, r, 0);

        // SHA-384, no swap, running length 4 then 8
        bwrite(8'h08, 32'h0);
        bwrite(8'h60, 32'h1);
        bwrite(8'h10, 32'd4);
        bwrite(8'h14, 32'h11223344);
        bwrite(8'h10, 32'd8);
        bwrite(8'h14, 32'h55667788);
        bwrite(8'h10, 32'd6);
        bwrite(8'h14, 32'hAABB0000);
        bwrite(8'h18, 32'h1);
        poll_valid();
        bread(8'h4C, r); chk("R11 word11", r != 0, r, 32'h1);
        bread(8'h50, r); chk("R11 word12", r == 0, r, 0);
        bread(8'h5C, r); chk("R11 word15", r == 0, r, 0);

        // R12: zeroize
        bwrite(8'h60, 32'h1);
        bread(8'h20, r); chk("R12 digest", r == 0, r, 0);
        bread(8'h1C, r); chk("R12 status", r == 32'h2, r, 32'h2);
        bwrite(8'h00, 32'h1);
        repeat (2) @(posedge clk);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule